// File: doc/BRIEF.md
# Euler-Step Differential-Equation Solver Core

This core integrates a second-order differential equation numerically with forward-Euler steps, working on signed Q8.8 fixed-point values. A start pulse given while the core is idle captures an initial position `x`, solution `y`, derivative `u`, step size `dx` and an end bound `a`. The core then repeats one update step until the loop condition clears. When the loop ends, it raises `done` for one cycle and presents the final `y`.

Each step uses the values held before that step. It forms `x + dx`, `u - 3*x*u*dx - 3*y*dx`, `y + u*dx` and the flag `x < a`, and then writes the three new state values in one edge. The arithmetic runs on a fixed pool of two multipliers and two adder/comparator units. A static four-slot schedule time-shares this pool, and operand multiplexers pick each unit's inputs in every slot. Two product registers carry the results of the multipliers from one slot to the next.

Top module: `ode_euler_core`

## Requirements
- R1: While reset is asserted, and after it is released, `busy`, `done`, `y_out` and `iter_cnt` are all zero until the first start.
- R2: When `start` is high while `busy` is low, the core captures all five operand inputs on that edge, and `busy` is high from the next cycle.
- R3: Each update step takes exactly four cycles. `done` rises 4·N clock edges after the edge that sampled `start`, where N is the number of steps executed.
- R4: Every product is the full signed product shifted right arithmetically by 8 bits (floor) and cut to 16 bits. The constant 3 enters a multiplier as the Q8.8 value 0x0300. Sums and differences wrap modulo 2^16. The reported `y` equals the result of the described update run in this arithmetic.
- R5: The update body executes at least once, even when `x >= a` at start.
- R6: Another step follows only when the `x` from before the update is less than `a`, compared as signed two's-complement numbers.
- R7: `done` is high for exactly one cycle. `y_out` keeps its value from that cycle until a later run finishes.
- R8: A `start` pulse that arrives while `busy` is high has no effect on the result or the step count of the run in progress.
- R9: `iter_cnt` clears on an accepted start, rises by one with each completed step, and holds the number of steps executed once `done` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; accepted only while idle |
| x_in | input | DATA_W | Initial position, Q8.8 |
| y_in | input | DATA_W | Initial solution value, Q8.8 |
| u_in | input | DATA_W | Initial derivative, Q8.8 |
| dx_in | input | DATA_W | Step size, Q8.8 |
| a_in | input | DATA_W | End bound for position, Q8.8 |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| y_out | output | DATA_W | Final solution value |
| iter_cnt | output | ITER_W | Steps executed in the current or last run |

## Verification
The bench builds the core with its defaults: DATA_W=16, FRAC_W=8 and ITER_W=16. At this width, a step can carry negative products through the floor truncation and wrap its sums. A position below zero can also face a bound above zero, which separates the signed comparison from an unsigned one. The operand sets yield runs of 1 to about a dozen steps, so the bench can check the four-cycle step timing against the step count. A start pulse issued in the middle of a run is checked for having no effect on that run.

// File: rtl/ode_pkg.sv
package ode_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_S0   = 3'd1,
    ST_S1   = 3'd2,
    ST_S2   = 3'd3,
    ST_S3   = 3'd4
  } step_e;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_LT  = 2'd2
  } alu_op_e;

  localparam int NUM_MUL = 2;
  localparam int NUM_ALU = 2;
endpackage

// File: rtl/ode_mul_unit.sv
module ode_mul_unit #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 8
) (
  input  logic signed [DATA_W-1:0] op_a,
  input  logic signed [DATA_W-1:0] op_b,
  output logic signed [DATA_W-1:0] prod
);
  localparam int FULL_W = 2 * DATA_W;

  logic signed [FULL_W-1:0] full;

  always_comb begin
    full = op_a * op_b;
    // floor truncation back to the operand format
    prod = full[FRAC_W+DATA_W-1:FRAC_W];
  end
endmodule

// File: rtl/ode_alu_unit.sv
module ode_alu_unit
  import ode_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e                  op,
  input  logic signed [DATA_W-1:0] op_a,
  input  logic signed [DATA_W-1:0] op_b,
  output logic signed [DATA_W-1:0] res
);
  always_comb begin
    unique case (op)
      ALU_ADD: res = op_a + op_b;
      ALU_SUB: res = op_a - op_b;
      ALU_LT:  res = {{(DATA_W-1){1'b0}}, (op_a < op_b)};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/ode_sched_ctrl.sv
module ode_sched_ctrl
  import ode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  cont,
  output step_e step,
  output logic  load_en,
  output logic  commit_en,
  output logic  exit_en,
  output logic  done
);
  step_e state_q, state_d;
  logic  done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_S0;
      ST_S0:   state_d = ST_S1;
      ST_S1:   state_d = ST_S2;
      ST_S2:   state_d = ST_S3;
      ST_S3:   state_d = cont ? ST_S0 : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    load_en   = (state_q == ST_IDLE) && start;
    commit_en = (state_q == ST_S3);
    exit_en   = (state_q == ST_S3) && !cont;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= exit_en;
    end
  end

  assign step = state_q;
  assign done = done_q;
endmodule

// File: rtl/ode_euler_core.sv
module ode_euler_core
  import ode_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 8,
  parameter int ITER_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] x_in,
  input  logic [DATA_W-1:0] y_in,
  input  logic [DATA_W-1:0] u_in,
  input  logic [DATA_W-1:0] dx_in,
  input  logic [DATA_W-1:0] a_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] y_out,
  output logic [ITER_W-1:0] iter_cnt
);
  localparam logic signed [DATA_W-1:0] K_THREE = DATA_W'(3) << FRAC_W;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  step_e step;
  logic  load_en, commit_en, exit_en;
  logic  cont_q;

  ode_sched_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .cont      (cont_q),
    .step      (step),
    .load_en   (load_en),
    .commit_en (commit_en),
    .exit_en   (exit_en),
    .done      (done)
  );

  // state and intermediate registers
  logic signed [DATA_W-1:0] x_q, y_q, u_q, dx_q, a_q;
  logic signed [DATA_W-1:0] xn_q, usub_q;
  logic signed [DATA_W-1:0] prod_q [NUM_MUL];
  logic [DATA_W-1:0]        yout_q;
  logic [ITER_W-1:0]        iter_q;

  // unit operand steering
  logic signed [DATA_W-1:0] mul_a [NUM_MUL];
  logic signed [DATA_W-1:0] mul_b [NUM_MUL];
  logic signed [DATA_W-1:0] mul_p [NUM_MUL];
  alu_op_e                  alu_op [NUM_ALU];
  logic signed [DATA_W-1:0] alu_a [NUM_ALU];
  logic signed [DATA_W-1:0] alu_b [NUM_ALU];
  logic signed [DATA_W-1:0] alu_r [NUM_ALU];

  always_comb begin
    for (int i = 0; i < NUM_MUL; i++) begin
      mul_a[i] = '0;
      mul_b[i] = '0;
    end
    for (int i = 0; i < NUM_ALU; i++) begin
      alu_op[i] = ALU_ADD;
      alu_a[i]  = '0;
      alu_b[i]  = '0;
    end
    unique case (step)
      ST_S0: begin
        mul_a[0] = K_THREE;  mul_b[0] = x_q;      // 3x
        mul_a[1] = K_THREE;  mul_b[1] = y_q;      // 3y
        alu_op[0] = ALU_ADD; alu_a[0] = x_q;  alu_b[0] = dx_q;  // x + dx
        alu_op[1] = ALU_LT;  alu_a[1] = x_q;  alu_b[1] = a_q;   // x < a
      end
      ST_S1: begin
        mul_a[0] = prod_q[0]; mul_b[0] = u_q;     // 3x*u
        mul_a[1] = prod_q[1]; mul_b[1] = dx_q;    // 3y*dx
      end
      ST_S2: begin
        mul_a[0] = prod_q[0]; mul_b[0] = dx_q;    // 3xu*dx
        mul_a[1] = u_q;       mul_b[1] = dx_q;    // u*dx
        alu_op[0] = ALU_SUB; alu_a[0] = u_q; alu_b[0] = prod_q[1];
      end
      ST_S3: begin
        alu_op[0] = ALU_SUB; alu_a[0] = usub_q; alu_b[0] = prod_q[0];
        alu_op[1] = ALU_ADD; alu_a[1] = y_q;    alu_b[1] = prod_q[1];
      end
      default: ;
    endcase
  end

  for (genvar gm = 0; gm < NUM_MUL; gm++) begin : g_mul
    ode_mul_unit #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_mul (
      .op_a (mul_a[gm]),
      .op_b (mul_b[gm]),
      .prod (mul_p[gm])
    );
  end

  for (genvar ga = 0; ga < NUM_ALU; ga++) begin : g_alu
    ode_alu_unit #(.DATA_W(DATA_W)) u_alu (
      .op   (alu_op[ga]),
      .op_a (alu_a[ga]),
      .op_b (alu_b[ga]),
      .res  (alu_r[ga])
    );
  end

  // clock enables
  logic prod_en, s0_en, s2_en;
  always_comb begin
    prod_en = (step == ST_S0) || (step == ST_S1) || (step == ST_S2);
    s0_en   = (step == ST_S0);
    s2_en   = (step == ST_S2);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int i = 0; i < NUM_MUL; i++) prod_q[i] <= '0;
    end else if (prod_en) begin
      for (int i = 0; i < NUM_MUL; i++) prod_q[i] <= mul_p[i];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      xn_q   <= '0;
      cont_q <= 1'b0;
    end else if (s0_en) begin
      xn_q   <= alu_r[0];
      cont_q <= alu_r[1][0];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      usub_q <= '0;
    end else if (s2_en) begin
      usub_q <= alu_r[0];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      x_q  <= '0;
      y_q  <= '0;
      u_q  <= '0;
      dx_q <= '0;
      a_q  <= '0;
    end else if (load_en) begin
      x_q  <= x_in;
      y_q  <= y_in;
      u_q  <= u_in;
      dx_q <= dx_in;
      a_q  <= a_in;
    end else if (commit_en) begin
      x_q <= xn_q;
      u_q <= alu_r[0];
      y_q <= alu_r[1];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      yout_q <= '0;
    end else if (exit_en) begin
      yout_q <= alu_r[1];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      iter_q <= '0;
    end else if (load_en) begin
      iter_q <= '0;
    end else if (commit_en) begin
      iter_q <= iter_q + 1'b1;
    end
  end

  assign busy     = (step != ST_IDLE);
  assign y_out    = yout_q;
  assign iter_cnt = iter_q;
endmodule

// File: rtl/ode_euler_chk.sv
module ode_euler_chk #(
  parameter int DATA_W = 16,
  parameter int ITER_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] y_out,
  input logic [ITER_W-1:0] iter_cnt
);
  p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_fall_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_yout_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(y_out));

  p_iter_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(iter_cnt) |-> ((iter_cnt == ITER_W'($past(iter_cnt) + 1'b1)) || (iter_cnt == '0)));

  p_iter_min_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (iter_cnt != '0));
endmodule

bind ode_euler_core ode_euler_chk #(.DATA_W(DATA_W), .ITER_W(ITER_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .y_out    (y_out),
  .iter_cnt (iter_cnt)
);

// File: tb/ode_euler_core_tb_top.sv
module ode_euler_core_tb_top;
  localparam int DW = 16;
  localparam int IW = 16;
  localparam int NV = 7;

  typedef struct packed {
    logic [DW-1:0] x, y, u, dx, a;
  } vec_t;

  // stimulus operand sets; expected results come from the model below
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 16'h0100, 16'h0000, 16'h0040, 16'h0100},
    '{16'h0200, 16'h0180, 16'h0040, 16'h0020, 16'h0100},  // x >= a at start
    '{16'hFF00, 16'h0080, 16'hFF80, 16'h0020, 16'h0000},  // negative values
    '{16'h0000, 16'h0200, 16'h0100, 16'h0010, 16'h0080},
    '{16'hFF00, 16'h0040, 16'h0030, 16'h0200, 16'h0100},  // signed compare across zero
    '{16'hFC00, 16'hFE80, 16'h0250, 16'h0070, 16'hFE00},
    '{16'h0100, 16'h7F00, 16'h7000, 16'h0100, 16'h0300}   // wrapping sums
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [DW-1:0] x_in, y_in, u_in, dx_in, a_in;
  logic          busy, done;
  logic [DW-1:0] y_out;
  logic [IW-1:0] iter_cnt;

  int nchk = 0;
  int nbad = 0;

  always #2 clk = ~clk;

  ode_euler_core #(.DATA_W(DW), .FRAC_W(8), .ITER_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .x_in(x_in), .y_in(y_in), .u_in(u_in), .dx_in(dx_in), .a_in(a_in),
    .busy(busy), .done(done), .y_out(y_out), .iter_cnt(iter_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic signed [DW-1:0] qmul(input logic signed [DW-1:0] p, input logic signed [DW-1:0] q);
    logic signed [2*DW-1:0] f;
    f = p * q;
    return f[DW+7:8];
  endfunction

  function automatic void model(input vec_t v, output logic [DW-1:0] yf, output int n);
    logic signed [DW-1:0] x, y, u, dx, a, xn, un, yn;
    logic signed [DW-1:0] k3;
    bit c;
    k3 = 16'sh0300;
    x = v.x; y = v.y; u = v.u; dx = v.dx; a = v.a;
    n = 0;
    do begin
      xn = x + dx;
      un = u - qmul(qmul(qmul(k3, x), u), dx) - qmul(qmul(k3, y), dx);
      yn = y + qmul(u, dx);
      c  = (x < a);
      x = xn; u = un; y = yn;
      n++;
    end while (c && n < 1000);
    yf = y;
  endfunction

  task automatic drive(input vec_t v);
    x_in = v.x; y_in = v.y; u_in = v.u; dx_in = v.dx; a_in = v.a;
  endtask

  // issues a start and waits for done; returns cycles counted from the sampling edge
  task automatic launch(input vec_t v, input bit poke_busy, input vec_t v2, output int cyc);
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    chk(busy === 1'b1, "R2 busy after start", busy, 1);
    while (done !== 1'b1 && cyc < 5000) begin
      if (poke_busy && cyc == 3) begin
        drive(v2);
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    logic [DW-1:0] ye, yhold;
    int ne, cyc;
    rst_n = 1'b0;
    start = 1'b0;
    drive('0);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1 busy in reset", busy, 0);
    chk(done === 1'b0, "R1 done in reset", done, 0);
    chk(y_out === '0, "R1 y_out in reset", y_out, 0);
    chk(iter_cnt === '0, "R1 iter_cnt in reset", iter_cnt, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(busy === 1'b0 && y_out === '0, "R1 idle after release", y_out, 0);

    for (int i = 0; i < NV; i++) begin
      model(VECS[i], ye, ne);
      launch(VECS[i], 1'b0, VECS[i], cyc);
      chk(y_out === ye, "R4 final y", y_out, ye);
      chk(int'(iter_cnt) == ne, "R9 step count", iter_cnt, ne);
      chk(cyc == 4 * ne + 1, "R3 run length", cyc, 4 * ne + 1);
      if (i == 1) chk(ne == 1 && iter_cnt == 1, "R5 body once", iter_cnt, 1);
      if (i == 4) chk(iter_cnt == 2, "R6 signed compare", iter_cnt, 2);
      @(negedge clk);
      chk(done === 1'b0, "R7 done one cycle", done, 0);
      chk(y_out === ye, "R7 y_out held", y_out, ye);
    end

    // start while busy must not disturb the run
    model(VECS[0], ye, ne);
    launch(VECS[0], 1'b1, VECS[3], cyc);
    chk(y_out === ye, "R8 result unaffected", y_out, ye);
    chk(int'(iter_cnt) == ne, "R8 count unaffected", iter_cnt, ne);
    chk(cyc == 4 * ne + 1, "R8 timing unaffected", cyc, 4 * ne + 1);

    // idle hold: operands change without start
    yhold = y_out;
    drive(VECS[5]);
    repeat (20) @(negedge clk);
    chk(y_out === yhold && done === 1'b0 && busy === 1'b0, "R7 hold while idle", y_out, yhold);

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule